// File: doc/BRIEF.md
# Boundary-Scan Cell Chain for Bidirectional Pins

This block places three boundary-scan cells in front of each of `PIN_COUNT` bidirectional pins and links all of them into one serial chain. For every pin, one cell watches the pad input, one sets the value the pad drives, and one sets whether the pad drives at all. A test access controller outside the block drives the capture, shift and update strobes and the mode select, all timed by the test clock.

Each cell has two stages. The shift stage is a flop that either samples the cell's parallel input on capture or takes its serial neighbour's value on shift. The hold stage is loaded from the shift stage only on an update strobe. In normal mode the core signals pass straight to the pad buffer and back, and the cells only observe. In test mode the pad buffer and the core's input are driven from the hold stages. Because the hold stages are separate, shifting new data in leaves the pins undisturbed until the next update.

The cells sit in a fixed order. Pin 0 is nearest the serial output. Within each pin, counting from the serial output, the order is enable cell, then output-data cell, then input cell.

Top module: `bscan_pin_group`

## Requirements
- R1: While `rstN` is low, every shift stage and hold stage is cleared asynchronously, so `scanOut` is 0. In test mode `padOut`, `padOe` and `coreIn` are then all 0.
- R2: When `testMode` is 0, the pad signals follow the core combinationally: `padOut` equals `coreOut`, `padOe` equals `coreOe`, and `coreIn` equals `padIn`.
- R3: On a clock edge with `captureEn` high, each pin's shift stages load as follows: the enable cell loads `coreOe[p]`, the output cell loads `coreOut[p]` and the input cell loads `padIn[p]`. This holds even when `shiftEn` is also high, because capture takes precedence over shift.
- R4: The chain positions are numbered from `scanOut` starting at 0. Position 3p holds pin p's enable cell, 3p+1 its output cell and 3p+2 its input cell. After a capture, the bit that appears on `scanOut` after k shifts is the content of position k.
- R5: On a clock edge with `shiftEn` high and `captureEn` low, each stage takes the value of its neighbour one position further from `scanOut`. Position 3·PIN_COUNT−1 takes `scanIn`, so the chain is 3·PIN_COUNT bits long and `scanOut` is position 0.
- R6: On a clock edge with `updateEn` high, every hold stage loads the value its shift stage held before that edge.
- R7: Without an update strobe, capture and shift leave every hold stage, and so every test-mode pad and core output, unchanged.
- R8: When `testMode` is 1, `padOut[p]`, `padOe[p]` and `coreIn[p]` are driven from the hold stages at positions 3p+1, 3p and 3p+2 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low test reset |
| captureEn | input | 1 | Capture strobe: shift stages sample parallel inputs |
| shiftEn | input | 1 | Shift strobe: chain moves one position toward scanOut |
| updateEn | input | 1 | Update strobe: hold stages load shift stages |
| testMode | input | 1 | 1 selects hold-stage drive, 0 selects core pass-through |
| scanIn | input | 1 | Serial data into the chain (far end) |
| scanOut | output | 1 | Serial data out of the chain (position 0) |
| coreOut | input | PIN_COUNT | Output data from core logic |
| coreOe | input | PIN_COUNT | Output enable from core logic |
| coreIn | output | PIN_COUNT | Input data presented to core logic |
| padIn | input | PIN_COUNT | Data received by each pad buffer |
| padOut | output | PIN_COUNT | Data driven to each pad buffer |
| padOe | output | PIN_COUNT | Output enable to each pad buffer |

## Verification
The bench builds the block with `PIN_COUNT` = 4, which gives a 12-bit chain. At that size every one of the 4096 possible chain contents can be shifted in, updated and decoded onto the pins in test mode. During each load, the bench checks the previous contents as they come out on `scanOut` and checks that the pins do not move before the update. All 16 core-output patterns are captured and shifted out, once with capture alone and once with shift asserted at the same time, to confirm the position order and the capture precedence. Normal-mode pass-through is swept over all input combinations of one pin pair pattern set.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Strobes handed from the control decode to the cell datapath.
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic drive;
  } scanStrobes_t;

  // Cell role within a pin; value is the offset from the pin's base position.
  typedef enum logic [1:0] {
    CELL_ENABLE = 2'd0,
    CELL_DATA   = 2'd1,
    CELL_INPUT  = 2'd2
  } cellRole_t;

  localparam int CELLS_PER_PIN = 3;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic         captureEn,
  input  logic         shiftEn,
  input  logic         updateEn,
  input  logic         testMode,
  output scanStrobes_t strobes
);

  // Capture has precedence: a shift requested alongside it is dropped.
  always_comb begin
    strobes.capture = captureEn;
    strobes.shift   = shiftEn & ~captureEn;
    strobes.update  = updateEn;
    strobes.drive   = testMode;
  end

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  scanStrobes_t strobes,
  input  logic         serIn,
  input  logic         parIn,
  output logic         serOut,
  output logic         holdOut
);

  logic shiftQ;
  logic holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= 1'b0;
    end else if (strobes.capture) begin
      shiftQ <= parIn;
    end else if (strobes.shift) begin
      shiftQ <= serIn;
    end
  end

  // Hold stage samples the shift stage's pre-edge value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b0;
    end else if (strobes.update) begin
      holdQ <= shiftQ;
    end
  end

  assign serOut  = shiftQ;
  assign holdOut = holdQ;

endmodule

// File: rtl/bscan_datapath.sv
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  scanStrobes_t           strobes,
  input  logic                   scanIn,
  output logic                   scanOut,
  input  logic [PIN_COUNT-1:0]   coreOut,
  input  logic [PIN_COUNT-1:0]   coreOe,
  output logic [PIN_COUNT-1:0]   coreIn,
  input  logic [PIN_COUNT-1:0]   padIn,
  output logic [PIN_COUNT-1:0]   padOut,
  output logic [PIN_COUNT-1:0]   padOe,
  output logic [CELLS_PER_PIN*PIN_COUNT-1:0] chainBits,
  output logic [CELLS_PER_PIN*PIN_COUNT-1:0] holdBits
);

  localparam int CHAIN_LEN = CELLS_PER_PIN * PIN_COUNT;

  logic [CHAIN_LEN-1:0] parVec;
  logic [CHAIN_LEN:0]   serLink;

  // serLink[k+1] feeds position k; the far end is the chain input.
  assign serLink[CHAIN_LEN] = scanIn;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    localparam int BASE = CELLS_PER_PIN * p;

    assign parVec[BASE + int'(CELL_ENABLE)] = coreOe[p];
    assign parVec[BASE + int'(CELL_DATA)]   = coreOut[p];
    assign parVec[BASE + int'(CELL_INPUT)]  = padIn[p];

    for (genvar c = 0; c < CELLS_PER_PIN; c++) begin : g_cell
      bscan_cell cell_i (
        .clk     (clk),
        .rstN    (rstN),
        .strobes (strobes),
        .serIn   (serLink[BASE + c + 1]),
        .parIn   (parVec[BASE + c]),
        .serOut  (serLink[BASE + c]),
        .holdOut (holdBits[BASE + c])
      );
    end

    always_comb begin
      if (strobes.drive) begin
        padOut[p] = holdBits[BASE + int'(CELL_DATA)];
        padOe[p]  = holdBits[BASE + int'(CELL_ENABLE)];
        coreIn[p] = holdBits[BASE + int'(CELL_INPUT)];
      end else begin
        padOut[p] = coreOut[p];
        padOe[p]  = coreOe[p];
        coreIn[p] = padIn[p];
      end
    end
  end

  assign chainBits = serLink[CHAIN_LEN-1:0];
  assign scanOut   = serLink[0];

endmodule

// File: rtl/bscan_pin_group.sv
module bscan_pin_group
  import bscan_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 captureEn,
  input  logic                 shiftEn,
  input  logic                 updateEn,
  input  logic                 testMode,
  input  logic                 scanIn,
  output logic                 scanOut,
  input  logic [PIN_COUNT-1:0] coreOut,
  input  logic [PIN_COUNT-1:0] coreOe,
  output logic [PIN_COUNT-1:0] coreIn,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  localparam int CHAIN_LEN = CELLS_PER_PIN * PIN_COUNT;

  scanStrobes_t         strobes;
  logic [CHAIN_LEN-1:0] chainBits;
  logic [CHAIN_LEN-1:0] holdBits;

  bscan_ctrl ctrl_i (
    .captureEn (captureEn),
    .shiftEn   (shiftEn),
    .updateEn  (updateEn),
    .testMode  (testMode),
    .strobes   (strobes)
  );

  bscan_datapath #(.PIN_COUNT(PIN_COUNT)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .scanIn    (scanIn),
    .scanOut   (scanOut),
    .coreOut   (coreOut),
    .coreOe    (coreOe),
    .coreIn    (coreIn),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .chainBits (chainBits),
    .holdBits  (holdBits)
  );

endmodule

// File: rtl/bscan_pin_group_chk.sv
module bscan_pin_group_chk #(
  parameter int PIN_COUNT = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   captureEn,
  input logic                   shiftEn,
  input logic                   updateEn,
  input logic                   testMode,
  input logic                   scanIn,
  input logic                   scanOut,
  input logic [PIN_COUNT-1:0]   coreOut,
  input logic [PIN_COUNT-1:0]   coreOe,
  input logic [PIN_COUNT-1:0]   coreIn,
  input logic [PIN_COUNT-1:0]   padIn,
  input logic [PIN_COUNT-1:0]   padOut,
  input logic [PIN_COUNT-1:0]   padOe,
  input logic [3*PIN_COUNT-1:0] chainBits,
  input logic [3*PIN_COUNT-1:0] holdBits
);

  localparam int LEN = 3 * PIN_COUNT;

  logic [LEN-1:0]       expCapture;
  logic [PIN_COUNT-1:0] holdData, holdEn, holdIn;

  always_comb begin
    for (int p = 0; p < PIN_COUNT; p++) begin
      expCapture[3*p]     = coreOe[p];
      expCapture[3*p + 1] = coreOut[p];
      expCapture[3*p + 2] = padIn[p];
      holdEn[p]           = holdBits[3*p];
      holdData[p]         = holdBits[3*p + 1];
      holdIn[p]           = holdBits[3*p + 2];
    end
  end

  // R1: reset clears the shift stages
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> (chainBits == '0 && holdBits == '0));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (padOut == coreOut && padOe == coreOe && coreIn == padIn));

  assert_capture_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> chainBits == $past(expCapture));

  assert_serial_tap_R4: assert property (@(posedge clk) disable iff (!rstN)
    scanOut == chainBits[0]);

  assert_shift_move_R5: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !captureEn) |=>
      chainBits == {$past(scanIn), $past(chainBits[LEN-1:1])});

  assert_update_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    updateEn |=> holdBits == $past(chainBits));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !updateEn |=> $stable(holdBits));

  assert_test_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (padOut == holdData && padOe == holdEn && coreIn == holdIn));

endmodule

bind bscan_pin_group bscan_pin_group_chk #(.PIN_COUNT(PIN_COUNT)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .captureEn (captureEn),
  .shiftEn   (shiftEn),
  .updateEn  (updateEn),
  .testMode  (testMode),
  .scanIn    (scanIn),
  .scanOut   (scanOut),
  .coreOut   (coreOut),
  .coreOe    (coreOe),
  .coreIn    (coreIn),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOe     (padOe),
  .chainBits (chainBits),
  .holdBits  (holdBits)
);

// File: tb/bscan_pin_group_tb.sv
`timescale 1ns/1ps
module bscan_pin_group_tb_top;

  localparam int NP  = 4;
  localparam int LEN = 3 * NP;

  logic          clk = 1'b0;
  logic          rstN;
  logic          captureEn, shiftEn, updateEn, testMode, scanIn;
  logic          scanOut;
  logic [NP-1:0] coreOut, coreOe, coreIn, padIn, padOut, padOe;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  bscan_pin_group #(.PIN_COUNT(NP)) dut_i (
    .clk(clk), .rstN(rstN), .captureEn(captureEn), .shiftEn(shiftEn),
    .updateEn(updateEn), .testMode(testMode), .scanIn(scanIn),
    .scanOut(scanOut), .coreOut(coreOut), .coreOe(coreOe), .coreIn(coreIn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock: inputs change after the falling edge, results read there too.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NP-1:0] pick(input logic [LEN-1:0] v, input int role);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = v[3*p + role];
    return r;
  endfunction

  // Capture with given stimulus, then shift out and compare position by position.
  task automatic captureAndDrain(input logic [NP-1:0] vo, input logic [NP-1:0] ve,
                                 input logic [NP-1:0] vi, input bit withShift);
    logic [LEN-1:0] exp;
    for (int p = 0; p < NP; p++) begin
      exp[3*p]     = ve[p];
      exp[3*p + 1] = vo[p];
      exp[3*p + 2] = vi[p];
    end
    coreOut = vo; coreOe = ve; padIn = vi;
    captureEn = 1'b1; shiftEn = withShift;
    cycle();
    captureEn = 1'b0; shiftEn = 1'b1; scanIn = 1'b0;
    for (int k = 0; k < LEN; k++) begin
      #0.1;
      if (withShift) check("R3 capture precedence", {31'd0, scanOut}, {31'd0, exp[k]});
      else           check("R4 order after capture", {31'd0, scanOut}, {31'd0, exp[k]});
      cycle();
    end
    shiftEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [LEN-1:0] prev;
    rstN = 1'b0; captureEn = 0; shiftEn = 0; updateEn = 0; testMode = 1'b1;
    scanIn = 0; coreOut = '1; coreOe = '1; padIn = '1;
    repeat (2) @(negedge clk);
    #0.1;
    // R1: reset state
    check("R1 scanOut", {31'd0, scanOut}, 32'd0);
    check("R1 padOut", {28'd0, padOut}, 32'd0);
    check("R1 padOe", {28'd0, padOe}, 32'd0);
    check("R1 coreIn", {28'd0, coreIn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: pass-through sweep in normal mode
    testMode = 1'b0;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        coreOut = a[NP-1:0]; coreOe = b[NP-1:0]; padIn = a[NP-1:0] ^ b[NP-1:0] ^ 4'h6;
        #0.1;
        check("R2 padOut", {28'd0, padOut}, {28'd0, coreOut});
        check("R2 padOe", {28'd0, padOe}, {28'd0, coreOe});
        check("R2 coreIn", {28'd0, coreIn}, {28'd0, padIn});
      end
    end

    // R4 and R3: capture every core-output pattern and drain the chain
    for (int v = 0; v < 16; v++) begin
      captureAndDrain(v[NP-1:0], ~v[NP-1:0] ^ 4'h3, v[NP-1:0] ^ 4'hA, 1'b0);
      captureAndDrain(v[NP-1:0] ^ 4'h5, v[NP-1:0], ~v[NP-1:0], 1'b1);
    end

    // R5/R6/R7/R8: exhaustive load of all chain contents in test mode
    testMode = 1'b1;
    coreOut = '0; coreOe = '0; padIn = '0;
    // Chain currently all zero after the last drain; hold stages still zero.
    prev = '0;
    for (int w = 0; w < (1 << LEN); w++) begin
      logic [LEN-1:0] wv;
      wv = w[LEN-1:0];
      shiftEn = 1'b1;
      for (int j = 0; j < LEN; j++) begin
        scanIn = wv[j];
        #0.1;
        check("R5 shifted-out bit", {31'd0, scanOut}, {31'd0, prev[j]});
        cycle();
        #0.1;
        check("R7 pins held during shift", {28'd0, padOut}, {28'd0, pick(prev, 1)});
      end
      shiftEn = 1'b0;
      updateEn = 1'b1;
      cycle();
      updateEn = 1'b0;
      #0.1;
      check("R6/R8 padOut after update", {28'd0, padOut}, {28'd0, pick(wv, 1)});
      check("R8 padOe from enable cells", {28'd0, padOe}, {28'd0, pick(wv, 0)});
      check("R8 coreIn from input cells", {28'd0, coreIn}, {28'd0, pick(wv, 2)});
      prev = wv;
    end

    // R7: a capture without update leaves the pins alone
    coreOut = ~pick(prev, 1); coreOe = ~pick(prev, 0); padIn = ~pick(prev, 2);
    captureEn = 1'b1;
    cycle();
    captureEn = 1'b0;
    #0.1;
    check("R7 pins held after capture", {28'd0, padOe}, {28'd0, pick(prev, 0)});

    // R1: asynchronous reset mid-run clears hold stages
    #1 rstN = 1'b0;
    #0.1;
    check("R1 async clear padOut", {28'd0, padOut}, 32'd0);
    check("R1 async clear scanOut", {31'd0, scanOut}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule